// File: doc/BRIEF.md
# Wiper Position Register with Stored-Value Recall

This block keeps the 7-bit position of a digitally controlled potentiometer wiper. Beside it sits a one-bit volatile access mode flag. A serial front end reaches both through a small byte-wide register port. The block claims only the top four byte addresses of the memory map and leaves every other address to other logic.

The power-up default of the wiper is the middle tap. Once the supply is reported good, the block reads the stored initial-value byte from a non-volatile store over a request/acknowledge handshake and loads it into the wiper. Until that recall is done, the register port gives no response to any access.

The mode flag decides two things for the wiper address. It chooses whether a read returns the live wiper or the stored copy. It also chooses whether a write touches only the live wiper or also schedules an update of the stored copy. The live wiper always changes as soon as the data byte arrives. The stored copy is written only after the front end signals the end of the bus transaction. The block also drives a one-hot tap select to the resistor ladder.

Top module: `wiper_ctrl`

## Requirements
- R1: While reset is high and afterwards until recall completes, the wiper holds 0x40, the mode flag is 0 and `ready` is low. No store request is made before `supply_ok` is high.
- R2: After `supply_ok` rises, the block makes exactly one store read. It loads the low 7 bits of the returned byte into the wiper and then raises `ready`, which stays high until reset.
- R3: While `ready` is low, no access produces `acc_done`, and no access changes the wiper or the flag.
- R4: Slot 2 (address 0x7FE) reads as the flag in bit 7 with bits 6..0 zero. A write to slot 2 whose bits 6..0 are zero copies bit 7 into the flag and answers with `acc_ok`=1.
- R5: A write to slot 2 with any of bits 6..0 set answers `acc_done` with `acc_ok`=0, and the flag keeps its value.
- R6: A read of slot 3 (address 0x7FF) returns the live wiper, zero-extended, when the flag is 1. When the flag is 0 it performs a store read and returns the stored byte unchanged.
- R7: A write to slot 3 with the flag at 1 sets the wiper to data bits 6..0 and never writes the store, even after `bus_stop`.
- R8: A write to slot 3 with the flag at 0 sets the wiper on the clock edge that accepts the access, before any `bus_stop`. The store receives the byte {0, data[6:0]}, and only after `bus_stop` is pulsed.
- R9: Slots 0 and 1 (0x7FC, 0x7FD) accept writes with `acc_ok`=1 and discard the data. Reads of them return 0x00.
- R10: An access whose address bits above bit 1 are not all ones gives no `acc_done` and changes nothing.
- R11: An access presented while a store read or store write is in progress gives no `acc_done` and changes nothing.
- R12: `tap_sel` has exactly one bit set, at the index equal to the wiper. Position 0x00 selects bit 0 and 0x7F selects bit 127.
- R13: Once `nv_req` is raised, it stays high until `nv_ack`. `nv_we` is high only while `nv_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| supply_ok | input | 1 | Supply is good enough for reliable store reads |
| acc_req | input | 1 | One-cycle access strobe from the serial front end |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 11 | Byte address of the access |
| acc_wdata | input | 8 | Write data byte |
| bus_stop | input | 1 | One-cycle pulse at the end of a bus transaction |
| acc_done | output | 1 | One-cycle pulse: access completed |
| acc_ok | output | 1 | Valid with `acc_done`: 1 = accepted, 0 = rejected |
| acc_rdata | output | 8 | Read data, valid with `acc_done` |
| ready | output | 1 | Recall has completed |
| wiper_pos | output | 7 | Live wiper position |
| tap_sel | output | 128 | One-hot tap select |
| nv_req | output | 1 | Store operation request, held until acknowledged |
| nv_we | output | 1 | Store operation is a write |
| nv_wdata | output | 8 | Byte to write to the store |
| nv_ack | input | 1 | Store operation complete |
| nv_rdata | input | 8 | Stored byte, valid with `nv_ack` |

## Verification
On every cycle, the assertions check these properties:
- The reset values.
- The silence of the port before recall.
- That a rejected mode write leaves the flag alone.
- The immediate wiper update on a write to the wiper address, and that no store write follows it at once.
- The one-hot tap select.
- The store handshake discipline.

Other behaviours need a bench scenario, because they depend on the store's contents or on a sequence of transactions:
- Loading the recalled value.
- The choice of read source by the mode flag.
- The deferral of the stored update until the end-of-transaction pulse.
- Discarding reserved and out-of-window accesses.
- Ignoring accesses during a store cycle.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    localparam int BYTE_W = 8;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_PWRWAIT,
        ST_RECALL,
        ST_IDLE,
        ST_NVREAD,
        ST_NVWRITE
    } wrp_state_e;

    // Low two address bits select a slot in the top window
    typedef enum logic [1:0] {
        SLOT_RSV0  = 2'd0,
        SLOT_RSV1  = 2'd1,
        SLOT_FLAG  = 2'd2,
        SLOT_WIPER = 2'd3
    } wrp_slot_e;

    typedef struct packed {
        logic              hit;
        logic              we;
        wrp_slot_e         slot;
        logic              low_clear;
        logic [BYTE_W-1:0] data;
    } wrp_cmd_t;

    function automatic logic low_bits_clear(input logic [BYTE_W-1:0] b);
        return (b[BYTE_W-2:0] == '0);
    endfunction

endpackage

// File: rtl/wrp_decode.sv
module wrp_decode
    import wrp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output wrp_cmd_t          cmd
);
    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_bits;
    logic            in_window;

    assign hi_bits   = addr[ADDR_W-1:2];
    assign in_window = &hi_bits;

    always_comb begin
        cmd.hit       = req && in_window;
        cmd.we        = we;
        cmd.slot      = wrp_slot_e'(addr[1:0]);
        cmd.low_clear = low_bits_clear(wdata);
        cmd.data      = wdata;
    end
endmodule

// File: rtl/wrp_commit.sv
module wrp_commit
    import wrp_pkg::*;
#(
    parameter int POS_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [POS_W-1:0]  arm_pos,
    input  logic              bus_stop,
    input  logic              launch,
    output logic              due,
    output logic [BYTE_W-1:0] wdata
);
    logic pending;
    logic stopped;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            stopped <= 1'b0;
            wdata   <= '0;
        end else if (launch) begin
            pending <= 1'b0;
            stopped <= 1'b0;
        end else begin
            if (arm) begin
                pending <= 1'b1;
                wdata   <= BYTE_W'(arm_pos);
            end
            if (bus_stop && (pending || arm)) begin
                stopped <= 1'b1;
            end
        end
    end

    assign due = pending && stopped;
endmodule

// File: rtl/wrp_tapdec.sv
module wrp_tapdec #(
    parameter int POS_W = 7
) (
    input  logic [POS_W-1:0]      pos,
    output logic [(1<<POS_W)-1:0] tap_sel
);
    localparam int TAPS = 1 << POS_W;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_sel[i] = (pos == POS_W'(i));
    end
endmodule

// File: rtl/wrp_ctrl.sv
module wrp_ctrl
    import wrp_pkg::*;
#(
    parameter int          POS_W     = 7,
    parameter int unsigned RESET_POS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  wrp_cmd_t          cmd,
    input  logic              commit_due,
    input  logic              nv_ack,
    input  logic [BYTE_W-1:0] nv_rdata,
    output logic [POS_W-1:0]  wiper,
    output logic              vol_only,
    output logic              ready,
    output logic              done,
    output logic              ok,
    output logic [BYTE_W-1:0] rdata,
    output logic              arm,
    output logic              launch,
    output logic              nv_req,
    output logic              nv_we
);
    localparam logic [POS_W-1:0] RST_VAL = RESET_POS[POS_W-1:0];

    wrp_state_e state;
    logic       idle;

    assign idle   = (state == ST_IDLE);
    assign ready  = (state != ST_PWRWAIT) && (state != ST_RECALL);
    assign nv_req = (state == ST_RECALL) || (state == ST_NVREAD) || (state == ST_NVWRITE);
    assign nv_we  = (state == ST_NVWRITE);
    assign arm    = idle && cmd.hit && cmd.we && (cmd.slot == SLOT_WIPER) && !vol_only;
    assign launch = idle && !cmd.hit && commit_due;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PWRWAIT;
            wiper    <= RST_VAL;
            vol_only <= 1'b0;
            done     <= 1'b0;
            ok       <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_PWRWAIT: begin
                    if (supply_ok) state <= ST_RECALL;
                end
                ST_RECALL: begin
                    if (nv_ack) begin
                        wiper <= nv_rdata[POS_W-1:0];
                        state <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (cmd.hit) begin
                        done  <= 1'b1;
                        ok    <= 1'b1;
                        rdata <= '0;
                        unique case (cmd.slot)
                            SLOT_WIPER: begin
                                if (cmd.we) begin
                                    wiper <= cmd.data[POS_W-1:0];
                                end else if (vol_only) begin
                                    rdata <= BYTE_W'(wiper);
                                end else begin
                                    done  <= 1'b0;
                                    state <= ST_NVREAD;
                                end
                            end
                            SLOT_FLAG: begin
                                if (cmd.we) begin
                                    if (cmd.low_clear) vol_only <= cmd.data[BYTE_W-1];
                                    else               ok       <= 1'b0;
                                end else begin
                                    rdata <= {vol_only, {(BYTE_W-1){1'b0}}};
                                end
                            end
                            SLOT_RSV0, SLOT_RSV1: begin
                                // reserved: writes discarded, reads zero
                            end
                        endcase
                    end else if (commit_due) begin
                        state <= ST_NVWRITE;
                    end
                end
                ST_NVREAD: begin
                    if (nv_ack) begin
                        rdata <= nv_rdata;
                        done  <= 1'b1;
                        ok    <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_NVWRITE: begin
                    if (nv_ack) state <= ST_IDLE;
                end
                default: state <= ST_PWRWAIT;
            endcase
        end
    end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wrp_pkg::*;
#(
    parameter int          ADDR_W    = 11,
    parameter int          POS_W     = 7,
    parameter int unsigned RESET_POS = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   supply_ok,
    input  logic                   acc_req,
    input  logic                   acc_we,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [BYTE_W-1:0]      acc_wdata,
    input  logic                   bus_stop,
    output logic                   acc_done,
    output logic                   acc_ok,
    output logic [BYTE_W-1:0]      acc_rdata,
    output logic                   ready,
    output logic [POS_W-1:0]       wiper_pos,
    output logic [(1<<POS_W)-1:0]  tap_sel,
    output logic                   nv_req,
    output logic                   nv_we,
    output logic [BYTE_W-1:0]      nv_wdata,
    input  logic                   nv_ack,
    input  logic [BYTE_W-1:0]      nv_rdata
);
    wrp_cmd_t cmd;
    logic     vol_only;
    logic     arm;
    logic     launch;
    logic     commit_due;

    wrp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req   (acc_req),
        .we    (acc_we),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .cmd   (cmd)
    );

    wrp_ctrl #(.POS_W(POS_W), .RESET_POS(RESET_POS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .supply_ok  (supply_ok),
        .cmd        (cmd),
        .commit_due (commit_due),
        .nv_ack     (nv_ack),
        .nv_rdata   (nv_rdata),
        .wiper      (wiper_pos),
        .vol_only   (vol_only),
        .ready      (ready),
        .done       (acc_done),
        .ok         (acc_ok),
        .rdata      (acc_rdata),
        .arm        (arm),
        .launch     (launch),
        .nv_req     (nv_req),
        .nv_we      (nv_we)
    );

    wrp_commit #(.POS_W(POS_W)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .arm_pos  (cmd.data[POS_W-1:0]),
        .bus_stop (bus_stop),
        .launch   (launch),
        .due      (commit_due),
        .wdata    (nv_wdata)
    );

    wrp_tapdec #(.POS_W(POS_W)) u_tapdec (
        .pos     (wiper_pos),
        .tap_sel (tap_sel)
    );
endmodule

// File: rtl/wrp_checker.sv
module wrp_checker
    import wrp_pkg::*;
#(
    parameter int          ADDR_W    = 11,
    parameter int          POS_W     = 7,
    parameter int unsigned RESET_POS = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ready,
    input logic                  acc_req,
    input logic                  acc_we,
    input logic [ADDR_W-1:0]     acc_addr,
    input logic [BYTE_W-1:0]     acc_wdata,
    input logic                  acc_done,
    input logic                  acc_ok,
    input logic [POS_W-1:0]      wiper_pos,
    input logic [(1<<POS_W)-1:0] tap_sel,
    input logic                  nv_req,
    input logic                  nv_we,
    input logic                  nv_ack,
    input logic                  vol_only
);
    localparam logic [POS_W-1:0]  RST_VAL   = RESET_POS[POS_W-1:0];
    localparam logic [ADDR_W-1:0] ADDR_FLAG = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic idle_now;
    logic wr_wiper;
    logic wr_flag_bad;

    assign idle_now    = ready && !nv_req;
    assign wr_wiper    = idle_now && acc_req && acc_we && (&acc_addr);
    assign wr_flag_bad = idle_now && acc_req && acc_we && (acc_addr == ADDR_FLAG)
                         && (acc_wdata[BYTE_W-2:0] != '0);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper_pos == RST_VAL && !vol_only && !ready));

    a_r3_silent_before_recall: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !acc_done);

    a_r5_flag_reject: assert property (@(posedge clk) disable iff (rst)
        wr_flag_bad |=> (acc_done && !acc_ok && vol_only == $past(vol_only)));

    a_r7_volatile_write: assert property (@(posedge clk) disable iff (rst)
        (wr_wiper && vol_only) |=> (wiper_pos == $past(acc_wdata[POS_W-1:0]) && !nv_req));

    a_r8_immediate_update: assert property (@(posedge clk) disable iff (rst)
        (wr_wiper && !vol_only) |=> (wiper_pos == $past(acc_wdata[POS_W-1:0]) && !nv_we));

    a_r12_tap_onehot: assert property (@(posedge clk) disable iff (rst)
        ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

    a_r13_req_held: assert property (@(posedge clk) disable iff (rst)
        (nv_req && !nv_ack) |=> nv_req);

    a_r13_we_in_req: assert property (@(posedge clk) disable iff (rst)
        nv_we |-> nv_req);
endmodule

bind wiper_ctrl wrp_checker #(
    .ADDR_W(ADDR_W), .POS_W(POS_W), .RESET_POS(RESET_POS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .acc_req   (acc_req),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_done  (acc_done),
    .acc_ok    (acc_ok),
    .wiper_pos (wiper_pos),
    .tap_sel   (tap_sel),
    .nv_req    (nv_req),
    .nv_we     (nv_we),
    .nv_ack    (nv_ack),
    .vol_only  (vol_only)
);

// File: tb/tb_wiper_ctrl.sv
module tb_wiper_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV_LAT     = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         supply_ok = 1'b0;
    logic         acc_req = 1'b0;
    logic         acc_we = 1'b0;
    logic [10:0]  acc_addr = '0;
    logic [7:0]   acc_wdata = '0;
    logic         bus_stop = 1'b0;
    logic         acc_done, acc_ok, ready;
    logic [7:0]   acc_rdata;
    logic [6:0]   wiper_pos;
    logic [127:0] tap_sel;
    logic         nv_req, nv_we;
    logic [7:0]   nv_wdata;
    logic         nv_ack;
    logic [7:0]   nv_rdata;

    logic [7:0]   nv_mem;
    int           nv_reads, nv_writes, lat_cnt;
    int           checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_ctrl dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .bus_stop(bus_stop), .acc_done(acc_done), .acc_ok(acc_ok), .acc_rdata(acc_rdata),
        .ready(ready), .wiper_pos(wiper_pos), .tap_sel(tap_sel),
        .nv_req(nv_req), .nv_we(nv_we), .nv_wdata(nv_wdata),
        .nv_ack(nv_ack), .nv_rdata(nv_rdata)
    );

    // behavioural store holding one byte
    always @(posedge clk) begin
        if (rst) begin
            nv_ack <= 1'b0; lat_cnt <= 0; nv_mem <= 8'h95;
            nv_reads <= 0; nv_writes <= 0; nv_rdata <= '0;
        end else if (nv_req && !nv_ack) begin
            if (lat_cnt == NV_LAT) begin
                nv_ack <= 1'b1; lat_cnt <= 0; nv_rdata <= nv_mem;
                if (nv_we) begin nv_mem <= nv_wdata; nv_writes <= nv_writes + 1; end
                else nv_reads <= nv_reads + 1;
            end else lat_cnt <= lat_cnt + 1;
        end else nv_ack <= 1'b0;
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_acc(input logic we, input logic [10:0] addr, input logic [7:0] wd,
                          output logic seen, output logic okv, output logic [7:0] rd,
                          output logic [6:0] w1);
        seen = 0; okv = 0; rd = '0;
        acc_req = 1'b1; acc_we = we; acc_addr = addr; acc_wdata = wd;
        @(negedge clk);
        w1 = wiper_pos;
        acc_req = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (acc_done && !seen) begin seen = 1; okv = acc_ok; rd = acc_rdata; end
            @(negedge clk);
        end
    endtask

    task automatic pulse_stop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    logic s, o; logic [7:0] r; logic [6:0] w;

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(wiper_pos == 7'h40, "R1 wiper", wiper_pos, 8'h40);
        chk(!ready, "R1 ready", ready, 0);
        chk(!nv_req, "R1 nv_req", nv_req, 0);
    endtask

    task automatic t_early();
        do_acc(1, 11'h7FF, 8'h11, s, o, r, w);
        chk(!s, "R3 no done write", s, 0);
        chk(wiper_pos == 7'h40, "R3 wiper kept", wiper_pos, 8'h40);
        do_acc(0, 11'h7FE, 8'h00, s, o, r, w);
        chk(!s, "R3 no done read", s, 0);
    endtask

    task automatic t_recall();
        supply_ok = 1'b1;
        for (int i = 0; i < 50 && !ready; i++) @(negedge clk);
        chk(ready, "R2 ready", ready, 1);
        chk(wiper_pos == 7'h15, "R2 recalled", wiper_pos, 8'h15);
        chk(nv_reads == 1, "R2 one read", nv_reads, 1);
    endtask

    task automatic t_flag_rw();
        do_acc(0, 11'h7FE, 8'h00, s, o, r, w);
        chk(s && r == 8'h00, "R4 flag reads 0", r, 8'h00);
        do_acc(1, 11'h7FE, 8'h80, s, o, r, w);
        chk(s && o, "R4 flag write ok", o, 1);
        do_acc(0, 11'h7FE, 8'h00, s, o, r, w);
        chk(s && r == 8'h80, "R4 flag reads 1", r, 8'h80);
    endtask

    task automatic t_volatile_write();
        int wr0;
        wr0 = nv_writes;
        do_acc(1, 11'h7FF, 8'h33, s, o, r, w);
        chk(w == 7'h33, "R7 wiper updated", w, 8'h33);
        do_acc(0, 11'h7FF, 8'h00, s, o, r, w);
        chk(s && r == 8'h33, "R6 live read", r, 8'h33);
        pulse_stop();
        repeat (12) @(negedge clk);
        chk(nv_writes == wr0 && nv_mem == 8'h95, "R7 store untouched", nv_mem, 8'h95);
    endtask

    task automatic t_flag_reject();
        do_acc(1, 11'h7FE, 8'h81, s, o, r, w);
        chk(s && !o, "R5 rejected", o, 0);
        do_acc(0, 11'h7FE, 8'h00, s, o, r, w);
        chk(r == 8'h80, "R5 flag kept", r, 8'h80);
    endtask

    task automatic t_stored_read();
        do_acc(1, 11'h7FE, 8'h00, s, o, r, w);
        do_acc(0, 11'h7FF, 8'h00, s, o, r, w);
        chk(s && r == 8'h95, "R6 stored read", r, 8'h95);
        chk(wiper_pos == 7'h33, "R6 wiper unchanged", wiper_pos, 8'h33);
    endtask

    task automatic t_store_write();
        int wr0;
        wr0 = nv_writes;
        do_acc(1, 11'h7FF, 8'hDA, s, o, r, w);
        chk(w == 7'h5A, "R8 immediate wiper", w, 8'h5A);
        chk(nv_writes == wr0 && nv_mem == 8'h95, "R8 no store before stop", nv_mem, 8'h95);
        pulse_stop();
        @(negedge clk);
        chk(nv_req && nv_we, "R8 store write started", nv_req, 1);
        do_acc(1, 11'h7FF, 8'h01, s, o, r, w);
        chk(!s, "R11 ignored during store", s, 0);
        chk(wiper_pos == 7'h5A, "R11 wiper kept", wiper_pos, 8'h5A);
        chk(nv_mem == 8'h5A && nv_writes == wr0 + 1, "R8 stored byte", nv_mem, 8'h5A);
    endtask

    task automatic t_reserved();
        do_acc(1, 11'h7FC, 8'h77, s, o, r, w);
        chk(s && o, "R9 rsv write ok", o, 1);
        do_acc(1, 11'h7FD, 8'h80, s, o, r, w);
        chk(s && o, "R9 rsv1 write ok", o, 1);
        do_acc(0, 11'h7FC, 8'h00, s, o, r, w);
        chk(s && r == 8'h00, "R9 rsv read", r, 8'h00);
        do_acc(0, 11'h7FE, 8'h00, s, o, r, w);
        chk(r == 8'h00, "R9 flag untouched", r, 8'h00);
        chk(wiper_pos == 7'h5A, "R9 wiper untouched", wiper_pos, 8'h5A);
    endtask

    task automatic t_outside();
        do_acc(1, 11'h3FF, 8'h22, s, o, r, w);
        chk(!s, "R10 no done", s, 0);
        do_acc(1, 11'h7FB, 8'h80, s, o, r, w);
        chk(!s, "R10 no done 7FB", s, 0);
        chk(wiper_pos == 7'h5A, "R10 wiper kept", wiper_pos, 8'h5A);
    endtask

    task automatic t_taps();
        do_acc(1, 11'h7FE, 8'h80, s, o, r, w);
        do_acc(1, 11'h7FF, 8'hFF, s, o, r, w);
        chk(tap_sel[127] && $countones(tap_sel) == 1, "R12 top tap", wiper_pos, 8'h7F);
        do_acc(1, 11'h7FF, 8'h00, s, o, r, w);
        chk(tap_sel[0] && $countones(tap_sel) == 1, "R12 bottom tap", wiper_pos, 8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_early();
        t_recall();
        t_flag_rw();
        t_volatile_write();
        t_flag_reject();
        t_stored_read();
        t_store_write();
        t_reserved();
        t_outside();
        t_taps();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule